// File: doc/BRIEF.md
# Registered Parity Bus Transceiver

A two-way, non-inverting bus transceiver with two 9-bit lanes on each side. Each lane holds eight data bits and one parity bit. The A-to-B path and the B-to-A path each have their own storage stage, and each stage has its own clock and its own latch enable. Each lane of each stage also has its own active-low clock enable. A stage can be transparent, so that its input flows straight to the opposite side. It can be latched, so that its value holds. It can also be clocked, so that a lane loads on a rising edge.

A single mode input selects how parity is handled.

- **Parity mode (mode low):** the parity bit sent out on each lane is rebuilt from the eight stored data bits. A polarity input selects odd or even parity. At the same time, every lane received on either side is checked against the same polarity. The result appears on an active-low error flag for that lane and side.
- **Feed-through mode (mode high):** the stored parity bit goes out unchanged, the error flags stay inactive, and the block acts as a plain 18-bit registered transceiver.

Tri-state drive is modelled as a value port plus an output-valid qualifier for each side. Each qualifier is set by its own active-low output enable.

Top module: `par_xcvr`

## Requirements
- R1: A synchronous reset, taken at the rising edge, clears both stores to zero. After reset, with the latch enable low, every data bit on both outputs is 0. In parity mode each lane's parity bit then equals the polarity input.
- R2: While a direction's latch enable is high, that direction's output follows its input in the same cycle, with no clock edge needed.
- R3: While the latch enable is low, a rising edge loads a lane only if that lane's active-low clock enable is low. The loaded lane then appears at the output after that edge.
- R4: While the latch enable is low, a lane whose clock enable is high holds its stored value. This holds across edges and whatever the input does, and each lane is independent of the other.
- R5: The two directions are independent. The A-to-B latch enable, clock and enables have no effect on the A-side output, and the B-to-A controls have no effect on the B-side output.
- R6: In parity mode (par_bypass = 0), each output lane's bit 8 is rebuilt from its bits 7:0, and the incoming parity bit is ignored. With odd_sel = 1 the 9-bit lane carries an odd number of ones; with odd_sel = 0 it carries an even number.
- R7: In feed-through mode (par_bypass = 1), all nine bits of each output lane, parity bit included, equal the stored or transparent lane unchanged.
- R8: Lane l occupies bits [9l+8 : 9l], with bit 9l+8 as its parity bit. In parity mode, err_a_n[l] (or err_b_n[l]) is 0 exactly when the number of ones in the 9 bits of lane l received on a_in (or b_in) is odd while odd_sel = 0, or even while odd_sel = 1.
- R9: In feed-through mode every error flag is 1, whatever the inputs are.
- R10: b_out_en equals the inverse of oe_ab_n and a_out_en equals the inverse of oe_ba_n. The enables have no effect on data or error flags.
- R11: While the latch enable is high, each rising edge loads every lane regardless of the clock enables. After the latch enable falls, the output holds the value present at the last such edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ab | input | 1 | Clock of the A-to-B store |
| clk_ba | input | 1 | Clock of the B-to-A store |
| rst | input | 1 | Synchronous reset of both stores, active high |
| le_ab | input | 1 | A-to-B latch enable, high = transparent |
| le_ba | input | 1 | B-to-A latch enable, high = transparent |
| cen_ab_n | input | 2 | A-to-B per-lane clock enable, active low |
| cen_ba_n | input | 2 | B-to-A per-lane clock enable, active low |
| oe_ab_n | input | 1 | Drive-B output enable, active low |
| oe_ba_n | input | 1 | Drive-A output enable, active low |
| par_bypass | input | 1 | 0 = parity generate/check, 1 = feed-through |
| odd_sel | input | 1 | 1 = odd parity, 0 = even parity |
| a_in | input | 18 | Value received on the A side |
| b_in | input | 18 | Value received on the B side |
| b_out | output | 18 | Value driven on the B side |
| b_out_en | output | 1 | B-side output valid |
| a_out | output | 18 | Value driven on the A side |
| a_out_en | output | 1 | A-side output valid |
| err_a_n | output | 2 | Per-lane parity error on A-side input, active low |
| err_b_n | output | 2 | Per-lane parity error on B-side input, active low |

## Verification
Transparent-path results, rebuilt parity, error flags and output enables are combinational. The bench therefore changes those inputs and checks 1 ns later, with no clock edge in between. Stored results are due one edge after the controls are set. The bench drives every input 1 ns after a rising edge and checks 1 ns after the next one, so each capture or hold is seen exactly one register stage later. Parity generation and checking are swept over all 512 lane values under both polarities and both modes. The hold and capture checks follow a per-lane model held in the bench.

// File: rtl/par_xcvr_pkg.sv
`timescale 1ns/1ps
package par_xcvr_pkg;
    typedef enum logic {
        PAR_ACTIVE = 1'b0,
        PAR_BYPASS = 1'b1
    } par_mode_e;

    function automatic logic parity_fill(input logic data_xor, input logic odd);
        return data_xor ^ odd;
    endfunction
endpackage

// File: rtl/par_store.sv
`timescale 1ns/1ps
module par_store #(
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    le,
    input  logic [LANES-1:0]        cen_n,
    input  logic [LANES*LANE_W-1:0] d,
    output logic [LANES*LANE_W-1:0] q
);
    localparam int TOT_W = LANES * LANE_W;

    typedef struct packed {
        logic [TOT_W-1:0] bits;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int l = 0; l < LANES; l++) begin
            if (le || !cen_n[l]) begin
                st_d.bits[l*LANE_W +: LANE_W] = d[l*LANE_W +: LANE_W];
            end
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign q = le ? d : st_q.bits;
endmodule

// File: rtl/par_lane_out.sv
`timescale 1ns/1ps
module par_lane_out
    import par_xcvr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W:0] lane_i,
    input  par_mode_e       mode,
    input  logic            odd_sel,
    output logic [DATA_W:0] lane_o
);
    logic par_bit;

    always_comb begin
        if (mode == PAR_BYPASS) begin
            par_bit = lane_i[DATA_W];
        end else begin
            par_bit = parity_fill(^lane_i[DATA_W-1:0], odd_sel);
        end
    end

    assign lane_o = {par_bit, lane_i[DATA_W-1:0]};
endmodule

// File: rtl/par_lane_chk.sv
`timescale 1ns/1ps
module par_lane_chk
    import par_xcvr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W:0] lane_i,
    input  par_mode_e       mode,
    input  logic            odd_sel,
    output logic            err_n
);
    logic ones_odd;

    assign ones_odd = ^lane_i;

    always_comb begin
        if (mode == PAR_BYPASS) begin
            err_n = 1'b1;
        end else begin
            err_n = (ones_odd == odd_sel);
        end
    end
endmodule

// File: rtl/par_xcvr.sv
`timescale 1ns/1ps
module par_xcvr
    import par_xcvr_pkg::*;
#(
    parameter int LANES  = 2,
    parameter int DATA_W = 8
) (
    input  logic                           clk_ab,
    input  logic                           clk_ba,
    input  logic                           rst,
    input  logic                           le_ab,
    input  logic                           le_ba,
    input  logic [LANES-1:0]               cen_ab_n,
    input  logic [LANES-1:0]               cen_ba_n,
    input  logic                           oe_ab_n,
    input  logic                           oe_ba_n,
    input  logic                           par_bypass,
    input  logic                           odd_sel,
    input  logic [LANES*(DATA_W+1)-1:0]    a_in,
    input  logic [LANES*(DATA_W+1)-1:0]    b_in,
    output logic [LANES*(DATA_W+1)-1:0]    b_out,
    output logic                           b_out_en,
    output logic [LANES*(DATA_W+1)-1:0]    a_out,
    output logic                           a_out_en,
    output logic [LANES-1:0]               err_a_n,
    output logic [LANES-1:0]               err_b_n
);
    localparam int LANE_W = DATA_W + 1;
    localparam int TOT_W  = LANES * LANE_W;

    logic [TOT_W-1:0] ab_q, ba_q;
    par_mode_e        mode;

    assign mode = par_mode_e'(par_bypass);

    par_store #(.LANES(LANES), .LANE_W(LANE_W)) u_store_ab (
        .clk   (clk_ab),
        .rst   (rst),
        .le    (le_ab),
        .cen_n (cen_ab_n),
        .d     (a_in),
        .q     (ab_q)
    );

    par_store #(.LANES(LANES), .LANE_W(LANE_W)) u_store_ba (
        .clk   (clk_ba),
        .rst   (rst),
        .le    (le_ba),
        .cen_n (cen_ba_n),
        .d     (b_in),
        .q     (ba_q)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        par_lane_out #(.DATA_W(DATA_W)) u_out_b (
            .lane_i  (ab_q[l*LANE_W +: LANE_W]),
            .mode    (mode),
            .odd_sel (odd_sel),
            .lane_o  (b_out[l*LANE_W +: LANE_W])
        );
        par_lane_out #(.DATA_W(DATA_W)) u_out_a (
            .lane_i  (ba_q[l*LANE_W +: LANE_W]),
            .mode    (mode),
            .odd_sel (odd_sel),
            .lane_o  (a_out[l*LANE_W +: LANE_W])
        );
        par_lane_chk #(.DATA_W(DATA_W)) u_chk_a (
            .lane_i  (a_in[l*LANE_W +: LANE_W]),
            .mode    (mode),
            .odd_sel (odd_sel),
            .err_n   (err_a_n[l])
        );
        par_lane_chk #(.DATA_W(DATA_W)) u_chk_b (
            .lane_i  (b_in[l*LANE_W +: LANE_W]),
            .mode    (mode),
            .odd_sel (odd_sel),
            .err_n   (err_b_n[l])
        );
    end

    assign b_out_en = ~oe_ab_n;
    assign a_out_en = ~oe_ba_n;
endmodule

// File: rtl/par_xcvr_chk.sv
`timescale 1ns/1ps
module par_xcvr_chk #(
    parameter int LANES  = 2,
    parameter int DATA_W = 8
) (
    input logic                        clk_ab,
    input logic                        rst,
    input logic                        le_ab,
    input logic [LANES-1:0]            cen_ab_n,
    input logic [LANES*(DATA_W+1)-1:0] a_in,
    input logic [LANES*(DATA_W+1)-1:0] b_out,
    input logic                        par_bypass,
    input logic                        odd_sel,
    input logic [LANES-1:0]            err_a_n,
    input logic [LANES-1:0]            err_b_n
);
    localparam int LANE_W = DATA_W + 1;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assert_gen_par_R6: assert property (@(posedge clk_ab) disable iff (rst)
            !par_bypass |-> ((^b_out[l*LANE_W +: LANE_W]) == odd_sel));

        assert_capture_R3: assert property (@(posedge clk_ab) disable iff (rst)
            (!le_ab && !cen_ab_n[l]) |=>
            (le_ab || (b_out[l*LANE_W +: DATA_W] == $past(a_in[l*LANE_W +: DATA_W]))));

        assert_hold_R4: assert property (@(posedge clk_ab) disable iff (rst)
            (!le_ab && cen_ab_n[l]) |=>
            (le_ab || $stable(b_out[l*LANE_W +: DATA_W])));
    end

    assert_err_idle_R9: assert property (@(posedge clk_ab) disable iff (rst)
        par_bypass |-> ((&err_a_n) && (&err_b_n)));
endmodule

bind par_xcvr par_xcvr_chk #(.LANES(LANES), .DATA_W(DATA_W)) u_par_xcvr_chk (
    .clk_ab     (clk_ab),
    .rst        (rst),
    .le_ab      (le_ab),
    .cen_ab_n   (cen_ab_n),
    .a_in       (a_in),
    .b_out      (b_out),
    .par_bypass (par_bypass),
    .odd_sel    (odd_sel),
    .err_a_n    (err_a_n),
    .err_b_n    (err_b_n)
);

// File: tb/par_xcvr_tb.sv
`timescale 1ns/1ps
module par_xcvr_tb;
    logic        clk_ab = 1'b0;
    logic        clk_ba = 1'b0;
    logic        rst = 1'b1;
    logic        le_ab = 1'b0, le_ba = 1'b0;
    logic [1:0]  cen_ab_n = 2'b11, cen_ba_n = 2'b11;
    logic        oe_ab_n = 1'b1, oe_ba_n = 1'b1;
    logic        par_bypass = 1'b0, odd_sel = 1'b1;
    logic [17:0] a_in = '0, b_in = '0;
    logic [17:0] b_out, a_out;
    logic        b_out_en, a_out_en;
    logic [1:0]  err_a_n, err_b_n;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk_ab = ~clk_ab;
    always #2.5 clk_ba = ~clk_ba;

    par_xcvr u_dut (
        .clk_ab(clk_ab), .clk_ba(clk_ba), .rst(rst),
        .le_ab(le_ab), .le_ba(le_ba),
        .cen_ab_n(cen_ab_n), .cen_ba_n(cen_ba_n),
        .oe_ab_n(oe_ab_n), .oe_ba_n(oe_ba_n),
        .par_bypass(par_bypass), .odd_sel(odd_sel),
        .a_in(a_in), .b_in(b_in),
        .b_out(b_out), .b_out_en(b_out_en),
        .a_out(a_out), .a_out_en(a_out_en),
        .err_a_n(err_a_n), .err_b_n(err_b_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk_ab);
        #1;
    endtask

    function automatic int ones(input logic [8:0] v);
        int c = 0;
        for (int i = 0; i < 9; i++) c += int'(v[i]);
        return c;
    endfunction

    // expected output lane from R6 / R7
    function automatic logic [8:0] exp_lane(input logic [8:0] v, input logic odd, input logic byp);
        int c;
        logic p;
        if (byp) return v;
        c = ones({1'b0, v[7:0]});
        p = odd ? ((c % 2) == 0) : ((c % 2) == 1);
        return {p, v[7:0]};
    endfunction

    // expected error flag from R8 / R9
    function automatic logic exp_err(input logic [8:0] v, input logic odd, input logic byp);
        if (byp) return 1'b1;
        return ((ones(v) % 2) == 1) == odd;
    endfunction

    logic [8:0] m_ab [2];
    logic [17:0] y1;

    initial begin
        repeat (3) @(posedge clk_ab);
        #1 rst = 1'b0;

        // R1: stores cleared, odd polarity gives parity bit 1 on zero data
        chk("R1 b_out", 32'(b_out), 32'h20100);
        chk("R1 a_out", 32'(a_out), 32'h20100);

        // R10: output enables
        chk("R10 b_en off", 32'(b_out_en), 0);
        chk("R10 a_en off", 32'(a_out_en), 0);
        oe_ab_n = 1'b0; #1;
        chk("R10 b_en on", 32'(b_out_en), 1);
        chk("R10 a_en stays", 32'(a_out_en), 0);
        oe_ba_n = 1'b0; oe_ab_n = 1'b1; #1;
        chk("R10 a_en on", 32'(a_out_en), 1);
        chk("R10 b_en off again", 32'(b_out_en), 0);

        // R2 R6 R7: transparent sweep
        le_ab = 1'b1;
        for (int v = 0; v < 512; v++) begin
            for (int o = 0; o < 2; o++) begin
                for (int b = 0; b < 2; b++) begin
                    logic [8:0] l0, l1;
                    l0 = 9'(v);
                    l1 = ~l0;
                    odd_sel = o[0]; par_bypass = b[0];
                    a_in = {l1, l0};
                    #1;
                    chk(b ? "R2 R7 transparent feed" : "R2 R6 transparent gen",
                        32'(b_out), 32'({exp_lane(l1, o[0], b[0]), exp_lane(l0, o[0], b[0])}));
                end
            end
        end

        // R8 R9: check sweep on both sides
        for (int v = 0; v < 512; v++) begin
            for (int o = 0; o < 2; o++) begin
                for (int b = 0; b < 2; b++) begin
                    logic [8:0] l0;
                    l0 = 9'(v);
                    odd_sel = o[0]; par_bypass = b[0];
                    a_in = {9'h000, l0};
                    b_in = {l0, 9'h000};
                    #1;
                    chk(b ? "R9 err_a idle" : "R8 err_a",
                        32'(err_a_n), 32'({exp_err(9'h000, o[0], b[0]), exp_err(l0, o[0], b[0])}));
                    chk(b ? "R9 err_b idle" : "R8 err_b",
                        32'(err_b_n), 32'({exp_err(l0, o[0], b[0]), exp_err(9'h000, o[0], b[0])}));
                end
            end
        end

        // R11: latch-edge load, then hold after latch enable falls
        par_bypass = 1'b1;
        le_ab = 1'b1;
        a_in = 18'h2A5C3;
        tick();
        le_ab = 1'b0;
        a_in = 18'h15A3C;
        #1;
        chk("R11 hold after le fall", 32'(b_out), 32'h2A5C3);
        m_ab[0] = 9'h1C3; m_ab[1] = 9'h152;
        tick();
        chk("R4 hold both lanes", 32'(b_out), 32'h2A5C3);

        // B-to-A value for R5
        le_ba = 1'b1; b_in = 18'h0F0F0;
        tick();
        le_ba = 1'b0; b_in = 18'h3FFFF;
        y1 = 18'h0F0F0;
        tick();
        chk("R5 a_out held", 32'(a_out), 32'(y1));

        // R3 R4: per-lane captures against a model
        for (int i = 0; i < 40; i++) begin
            logic [1:0] ce;
            logic [17:0] v;
            ce = 2'(i % 4);
            v = 18'((i * 18'h0B3D7 + 18'h01234) & 18'h3FFFF);
            cen_ab_n = ce;
            a_in = v;
            for (int l = 0; l < 2; l++) if (!ce[l]) m_ab[l] = v[l*9 +: 9];
            tick();
            chk("R3 R4 lane capture/hold", 32'(b_out), 32'({m_ab[1], m_ab[0]}));
        end
        cen_ab_n = 2'b11;

        // R5: A-to-B transparency leaves the A side alone
        le_ab = 1'b1;
        b_in = 18'h12345;
        a_in = 18'h0ABCD;
        tick();
        chk("R5 b_out transparent", 32'(b_out), 32'h0ABCD);
        chk("R5 a_out unaffected", 32'(a_out), 32'(y1));
        le_ab = 1'b0;

        // R1: reset again clears stores
        rst = 1'b1;
        tick();
        rst = 1'b0;
        par_bypass = 1'b0; odd_sel = 1'b0;
        #1;
        chk("R1 b_out after reset even", 32'(b_out), 0);
        chk("R1 a_out after reset even", 32'(a_out), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk_ab);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule